// File: doc/BRIEF.md
# Handshaked Control-Register Bus Responder

This block is the target side of a narrow, fully handshaked control-register bus. A master reaches a small bank of 16-bit configuration words through one shared 16-bit input bus and four strobe lines. One strobe captures an address and one captures a data word. One commits the held data to the held address, and one returns the addressed word. Each strobe is served on its rising edge. The block answers every served strobe with a level acknowledge, and that acknowledge is released only after the master drops the strobe.

The block exists so that a master sequencer can be verified against a target with realistic timing. A parameter sets how many clock cycles pass before the acknowledge rises, so a slow target can be modelled and a master's timeout path can be driven. The number of words in the bank is also a parameter. Addresses beyond the bank read as zero and absorb writes.

Top module: `crbus_responder`

## Requirements
- R1: A rising edge on `cap_addr_i` latches `din_i` as the held address.
- R2: A rising edge on `cap_data_i` latches `din_i` as the held data word. This alone does not change any stored word.
- R3: A rising edge on `wr_i` stores the held data word at the held address.
- R4: A rising edge on `rd_i` loads `dout_o` with the word at the held address, at the clock edge that accepts the strobe. This is never later than `ack_o` rising. `dout_o` keeps its value at all other times.
- R5: `ack_o` rises for each served strobe and stays high while that strobe is high. It falls on the first clock edge at which that strobe is sampled low. A strobe is accepted only while `ack_o` is low and no earlier strobe is pending.
- R6: `ack_o` rises exactly `ACK_DLY` clock edges after the edge that accepts the strobe. With `ACK_DLY` = 0 it rises on the accepting edge itself.
- R7: A held address of `DEPTH` or more reads as zero, and a write to it changes no stored word (no aliasing onto low addresses).
- R8: When several strobes rise on the same edge, only one is served: capture-address first, then capture-data, then write, then read. The others are ignored.
- R9: The held address keeps its value across any number of reads and writes until the next capture-address strobe.
- R10: Reset clears every stored word, the held address, the held data and `dout_o`, and holds `ack_o` low.
- R11: A strobe that rises while another access is pending or acknowledged is never served, even if it is still high after `ack_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_addr_i | input | 1 | Capture-address strobe |
| cap_data_i | input | 1 | Capture-data strobe |
| wr_i | input | 1 | Write-commit strobe |
| rd_i | input | 1 | Read strobe |
| din_i | input | DW | Shared address/data input bus |
| ack_o | output | 1 | Level acknowledge |
| dout_o | output | DW | Read data |

## Verification
The bench writes every implemented word with a computed pattern and reads each one back. It then writes to addresses past the bank and checks that they read zero and leave their low-bit aliases alone. A design that decoded only the low address bits would corrupt a live word at this point. The bench also raises strobes in pairs on one edge, to catch a wrong priority or a second action taken on the same edge. It raises a write strobe while a capture-data access is still acknowledged, to catch a design that serves a strobe by level rather than by edge. Acknowledge latency is measured on every access, so an off-by-one in the delay counter shows up at once. Resetting in mid-run then catches stored words or a held address that survive the reset.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

  // strobe vector bit order: 0 capture-address, 1 capture-data, 2 write, 3 read
  localparam int unsigned STB_N = 4;

  typedef enum logic [2:0] {K_NONE, K_ADDR, K_DATA, K_WR, K_RD} stb_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} seq_st_e;

  // fixed priority among strobes that rose on the same edge
  function automatic stb_kind_e pick_kind(input logic [STB_N-1:0] rise);
    if (rise[0])      return K_ADDR;
    else if (rise[1]) return K_DATA;
    else if (rise[2]) return K_WR;
    else if (rise[3]) return K_RD;
    else              return K_NONE;
  endfunction

  // current level of the strobe that belongs to a served access
  function automatic logic strobe_level(input stb_kind_e k, input logic [STB_N-1:0] lvl);
    case (k)
      K_ADDR:  return lvl[0];
      K_DATA:  return lvl[1];
      K_WR:    return lvl[2];
      K_RD:    return lvl[3];
      default: return 1'b0;
    endcase
  endfunction

  // an address is implemented when it is below the bank depth
  function automatic logic addr_in_range(input logic [15:0] a, input int unsigned depth);
    return {16'd0, a} < depth;
  endfunction

endpackage

// File: rtl/crbus_edge_pick.sv
module crbus_edge_pick
  import crbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_N-1:0] lvl,
  input  logic             accept_en,
  output logic [STB_N-1:0] rise,
  output stb_kind_e        kind,
  output logic             fire
);

  logic [STB_N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign kind = pick_kind(rise);
  assign fire = accept_en && (kind != K_NONE);

endmodule

// File: rtl/crbus_ack_seq.sv
module crbus_ack_seq
  import crbus_pkg::*;
#(
  parameter int unsigned ACK_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  stb_kind_e        kind,
  input  logic [STB_N-1:0] lvl,
  output logic             ack,
  output logic             idle,
  output logic             served_lvl
);

  localparam int unsigned CW = $clog2(ACK_DLY + 1) + 1;
  localparam logic [CW-1:0] LAST = (ACK_DLY == 0) ? '0 : CW'(ACK_DLY - 1);

  seq_st_e   st_q;
  stb_kind_e served_q;
  logic [CW-1:0] cnt_q;

  assign served_lvl = strobe_level(served_q, lvl);
  assign idle       = (st_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      served_q <= K_NONE;
      cnt_q    <= '0;
      ack      <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (fire) begin
            served_q <= kind;
            cnt_q    <= '0;
            if (ACK_DLY == 0) begin
              ack  <= 1'b1;
              st_q <= S_HOLD;
            end else begin
              st_q <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (cnt_q == LAST) begin
            ack  <= 1'b1;
            st_q <= S_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_HOLD: begin
          if (!served_lvl) begin
            ack      <= 1'b0;
            served_q <= K_NONE;
            st_q     <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crbus_regbank.sv
module crbus_regbank
  import crbus_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  stb_kind_e     kind,
  input  logic [15:0]   din,
  output logic [DW-1:0] dout,
  output logic [15:0]   held_addr,
  output logic [DW-1:0] held_data
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] words [DEPTH];
  logic          in_rng;
  logic [IW-1:0] idx;
  logic          wr_hit;

  assign in_rng = addr_in_range(held_addr, DEPTH);
  assign idx    = held_addr[IW-1:0];
  assign wr_hit = fire && (kind == K_WR) && in_rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_data <= '0;
      dout      <= '0;
    end else if (fire) begin
      case (kind)
        K_ADDR:  held_addr <= din;
        K_DATA:  held_data <= din[DW-1:0];
        K_RD:    dout      <= in_rng ? words[idx] : '0;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (wr_hit && (idx == IW'(g)))  word_q <= held_data;
    end
    assign words[g] = word_q;
  end

endmodule

// File: rtl/crbus_responder.sv
module crbus_responder
  import crbus_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned ACK_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_addr_i,
  input  logic          cap_data_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [15:0]   din_i,
  output logic          ack_o,
  output logic [DW-1:0] dout_o
);

  logic [STB_N-1:0] stb_lvl;
  logic [STB_N-1:0] ev_rise;
  stb_kind_e        ev_kind;
  logic             ev_fire;
  logic             seq_idle;
  logic             served_lvl;
  logic [15:0]      held_addr;
  logic [DW-1:0]    held_data;

  assign stb_lvl = {rd_i, wr_i, cap_data_i, cap_addr_i};

  crbus_edge_pick u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (stb_lvl),
    .accept_en (seq_idle),
    .rise      (ev_rise),
    .kind      (ev_kind),
    .fire      (ev_fire)
  );

  crbus_ack_seq #(.ACK_DLY(ACK_DLY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (ev_fire),
    .kind       (ev_kind),
    .lvl        (stb_lvl),
    .ack        (ack_o),
    .idle       (seq_idle),
    .served_lvl (served_lvl)
  );

  crbus_regbank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (ev_fire),
    .kind      (ev_kind),
    .din       (din_i),
    .dout      (dout_o),
    .held_addr (held_addr),
    .held_data (held_data)
  );

endmodule

// File: rtl/crbus_responder_chk.sv
module crbus_responder_chk
  import crbus_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_o,
  input logic [DW-1:0]    dout_o,
  input logic [15:0]      din_i,
  input logic             ev_fire,
  input stb_kind_e        ev_kind,
  input logic [STB_N-1:0] ev_rise,
  input logic             served_lvl,
  input logic [15:0]      held_addr,
  input logic [DW-1:0]    held_data
);

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_kind == K_ADDR) |=> (held_addr == $past(din_i)));

  p_data_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_kind == K_DATA) |=> (held_data == $past(din_i[DW-1:0])));

  p_dout_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fire && ev_kind == K_RD) |=> $stable(dout_o));

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && served_lvl) |=> ack_o);

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !served_lvl) |=> !ack_o);

  p_accept_when_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> !ack_o);

  p_oor_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_kind == K_RD && !addr_in_range(held_addr, DEPTH)) |=> (dout_o == '0));

  p_addr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_rise[0]) |-> (ev_kind == K_ADDR));

  p_addr_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fire && ev_kind == K_ADDR) |=> $stable(held_addr));

endmodule

bind crbus_responder crbus_responder_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_o      (ack_o),
  .dout_o     (dout_o),
  .din_i      (din_i),
  .ev_fire    (ev_fire),
  .ev_kind    (ev_kind),
  .ev_rise    (ev_rise),
  .served_lvl (served_lvl),
  .held_addr  (held_addr),
  .held_data  (held_data)
);

// File: tb/sim_crbus_responder.sv
`timescale 1ns/1ps
module sim_crbus_responder;

  localparam int unsigned DEPTH   = 16;
  localparam int unsigned DW      = 16;
  localparam int unsigned ACK_DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  stb = 4'b0;   // 0 addr, 1 data, 2 write, 3 read
  logic [15:0] din = '0;
  logic        ack;
  logic [15:0] dout;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] ref_mem [DEPTH];
  logic [15:0] last_dout;

  always #4 clk = ~clk;

  crbus_responder #(.DEPTH(DEPTH), .DW(DW), .ACK_DLY(ACK_DLY)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cap_addr_i(stb[0]), .cap_data_i(stb[1]), .wr_i(stb[2]), .rd_i(stb[3]),
    .din_i(din), .ack_o(ack), .dout_o(dout)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 32'h1357) ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // raise the strobes in m, wait for ack, hold, drop, check release
  task automatic drive(input logic [3:0] m, input logic [15:0] v, output logic [15:0] rdv);
    int lat;
    @(negedge clk);
    din = v;
    stb = m;
    lat = 0;
    while (!ack && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == ACK_DLY + 1, "R6 ack latency", lat, ACK_DLY + 1);
    rdv = dout;
    repeat (2) begin
      @(negedge clk);
      chk(ack == 1'b1, "R5 ack held while strobe high", ack, 1);
    end
    stb = 4'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R5 ack released after strobe low", ack, 0);
  endtask

  task automatic wr_word(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] x;
    drive(4'b0001, a, x);
    drive(4'b0010, d, x);
    drive(4'b0100, 16'h0, x);
  endtask

  task automatic rd_word(input logic [15:0] a, output logic [15:0] d);
    logic [15:0] x;
    drive(4'b0001, a, x);
    drive(4'b1000, 16'h0, d);
    last_dout = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0;

    // R10: reset state
    repeat (4) @(negedge clk);
    chk(ack == 1'b0, "R10 ack low in reset", ack, 0);
    chk(dout == 16'h0, "R10 dout clear in reset", dout, 0);
    rst_n = 1'b1;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h0, "R10 read at reset address", v, 0);

    // R1 R2 R3 R4: full sweep of the bank
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(16'(i), pat(i));
      ref_mem[i] = pat(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      rd_word(16'(i), v);
      chk(v == ref_mem[i], "R4 R3 readback sweep", v, ref_mem[i]);
    end

    // R9: held address persists over repeated reads
    rd_word(16'd5, v);
    drive(4'b1000, 16'h0, v);
    chk(v == ref_mem[5], "R9 second read same address", v, ref_mem[5]);

    // R2: capture-data alone stores nothing; R3 then commits
    drive(4'b0010, 16'h0BAD, v);
    drive(4'b1000, 16'h0, v);
    chk(v == ref_mem[5], "R2 data capture alone no store", v, ref_mem[5]);
    drive(4'b0100, 16'h0, v);
    ref_mem[5] = 16'h0BAD;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h0BAD, "R3 commit after data capture", v, 16'h0BAD);

    // R7: out-of-range addresses
    for (int k = 0; k < 4; k++) begin
      logic [15:0] oa;
      oa = (k == 0) ? 16'(DEPTH) : (k == 1) ? 16'(DEPTH + 3) : (k == 2) ? 16'h00FF : 16'hFFFF;
      wr_word(oa, 16'h7777);
      drive(4'b1000, 16'h0, v);
      chk(v == 16'h0, "R7 out-of-range reads zero", v, 0);
      rd_word(oa & 16'(DEPTH - 1), v);
      chk(v == ref_mem[oa & 16'(DEPTH - 1)], "R7 no alias write", v, ref_mem[oa & 16'(DEPTH - 1)]);
    end

    // R8: address beats read on the same edge
    rd_word(16'd9, v);
    drive(4'b1001, 16'd2, v);
    chk(v == ref_mem[9], "R8 read ignored beside address", v, ref_mem[9]);
    drive(4'b1000, 16'h0, v);
    chk(v == ref_mem[2], "R8 address taken", v, ref_mem[2]);
    // R8: data beats write
    drive(4'b0110, 16'h1234, v);
    drive(4'b1000, 16'h0, v);
    chk(v == ref_mem[2], "R8 write ignored beside data", v, ref_mem[2]);
    drive(4'b0100, 16'h0, v);
    ref_mem[2] = 16'h1234;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h1234, "R8 data taken", v, 16'h1234);
    // R8: address beats data
    drive(4'b0011, 16'd3, v);
    drive(4'b0100, 16'h0, v);
    ref_mem[3] = 16'h1234;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h1234, "R8 data ignored beside address", v, 16'h1234);
    last_dout = v;
    // R8: write beats read
    drive(4'b0001, 16'd7, v);
    drive(4'b1100, 16'h0, v);
    chk(v == last_dout, "R8 read ignored beside write", v, last_dout);
    ref_mem[7] = 16'h1234;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h1234, "R8 write taken", v, 16'h1234);

    // R11: write strobe raised while capture-data is acknowledged
    drive(4'b0001, 16'd3, v);
    ref_mem[3] = 16'h1234;
    @(negedge clk);
    din = 16'h4444;
    stb = 4'b0010;
    while (!ack) @(negedge clk);
    stb = 4'b0110;
    @(negedge clk);
    stb = 4'b0100;
    begin
      int hi;
      hi = 0;
      repeat (ACK_DLY + 6) begin
        @(negedge clk);
        if (ack) hi++;
      end
      chk(hi == 0, "R11 busy-time strobe not served", hi, 0);
    end
    stb = 4'b0000;
    @(negedge clk);
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h1234, "R11 no write from unserved strobe", v, 16'h1234);

    // R10: reset in mid-run clears bank and held address
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout == 16'h0, "R10 dout cleared by reset", dout, 0);
    rst_n = 1'b1;
    drive(4'b1000, 16'h0, v);
    chk(v == 16'h0, "R10 held address cleared", v, 0);
    rd_word(16'd3, v);
    chk(v == 16'h0, "R10 bank cleared", v, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule